// File: doc/BRIEF.md
# Byte-Lane Realignment and Packing Unit

This unit sits on a 64-bit data path between the beats read from a source and the shared transfer FIFO. A source region may start at any byte offset, and so may the destination. The unit moves every byte to the lane it must occupy at the destination, so the net rotation equals the destination offset minus the source offset, modulo eight. It emits words with byte strobes that mark which lanes carry payload.

A transfer is opened by a one-cycle `start` that carries the low three bits of both start addresses, a flag that says whether the destination address advances, and the total byte count. When the destination advances, partial input beats are merged so that every output word is full apart from the first and the last. When the destination stays at one address, each output word fills only the lanes from the destination offset to the top of the word. No bytes are carried across into the next word's low lanes. Up to seven leftover bytes wait in a holding register between beats. When the byte count is reached, any remainder is flushed without waiting for more input.

Top module: `byte_realigner`

## Requirements
- R1: A `start` pulse is taken only while no transfer is in progress. A `start` during a transfer leaves that transfer's output words unchanged.
- R2: Transfer byte k is read from input beat (src_off+k)/8, lane (src_off+k)%8. With `dst_incr`=1 it is emitted in output word (dst_off+k)/8, lane (dst_off+k)%8. Lane n of a word is bits 8n+7..8n.
- R3: Only input lanes from `src_off` upward in the first input beat, and from lane 0 in later beats, supply payload. Lanes past the byte count are ignored. Partial input beats are merged into one output word.
- R4: With `dst_incr`=1 the unit emits exactly ceil((dst_off+count)/8) words. Each word's `out_strb` has bit n set exactly when lane n carries payload.
- R5: With `dst_incr`=0 each output word carries up to 8-dst_off bytes in lanes dst_off upward, in byte order, and no byte appears below lane dst_off. The unit emits ceil(count/(8-dst_off)) words.
- R6: `out_last` is high on the final word of a transfer only. After that word is accepted, `out_valid` and `in_ready` stay low until the next `start`.
- R7: Bytes still held after the last input beat is accepted are emitted while `in_valid` is low.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_strb` hold their values on the next cycle.
- R9: During reset `out_valid` and `in_ready` are low.
- R10: A `start` with a byte count of zero opens no transfer: `out_valid` and `in_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a transfer when idle |
| src_off | input | 3 | Source start address, low bits |
| dst_off | input | 3 | Destination start address, low bits |
| dst_incr | input | 1 | 1: destination advances, 0: fixed destination |
| byte_count | input | 16 | Total bytes to move |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | 64 | Source beat |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 64 | Realigned word |
| out_strb | output | 8 | Byte strobes, bit n for lane n |
| out_last | output | 1 | Final word of the transfer |

## Verification
A wrong holding-byte count or lane offset puts the wrong byte or strobe into the very next output word. The bench compares every strobed lane of every word, so such a fault shows up within one word. A fault in the remaining-byte counters shows up as a missing, extra or wrongly flagged final word, or as the unit never returning to idle. Stall faults show up in the first cycle of the first stall, as a changed word or a high `in_ready`.

// File: rtl/byte_realigner.sv
module byte_realigner #(
  parameter int BYTES = 8,
  parameter int CNT_W = 16,
  localparam int OFF_W = $clog2(BYTES),
  localparam int DW = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-1:0] src_off,
  input  logic [OFF_W-1:0] dst_off,
  input  logic             dst_incr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [BYTES-1:0] out_strb,
  output logic             out_last
);
  localparam int NW = OFF_W + 1;

  logic [DW-1:0]    hold;
  logic [NW-1:0]    hcnt;
  logic [CNT_W-1:0] rem_in, rem_out;
  logic [OFF_W-1:0] so_q, do_q;
  logic             incr_q, first_in, first_out;

  function automatic logic [BYTES-1:0] lane_mask(input logic [NW-1:0] n);
    return ~({BYTES{1'b1}} << n);
  endfunction

  function automatic logic [DW-1:0] bit_mask(input logic [BYTES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < BYTES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  logic             busy, head, use_in, emit, in_fire, out_fire;
  logic [OFF_W-1:0] lane_in, lane_out;
  logic [NW-1:0]    room_in, room_out, n_in, need, total;
  logic [DW-1:0]    compact, fresh, hold_nx;
  logic [2*DW-1:0]  comb;

  assign busy     = rem_out != '0;
  assign head     = first_out || !incr_q;
  assign lane_in  = first_in ? so_q : '0;
  assign lane_out = head ? do_q : '0;
  assign room_in  = NW'(BYTES) - NW'(lane_in);
  assign room_out = NW'(BYTES) - NW'(lane_out);
  assign n_in     = (rem_in < CNT_W'(room_in)) ? NW'(rem_in) : room_in;
  assign need     = (rem_out < CNT_W'(room_out)) ? NW'(rem_out) : room_out;

  assign use_in   = busy && (hcnt < need) && in_valid && (rem_in != '0);
  assign compact  = (in_data >> (8 * lane_in)) & bit_mask(lane_mask(n_in));
  assign fresh    = use_in ? compact : '0;
  assign comb     = {{DW{1'b0}}, hold} | ({{DW{1'b0}}, fresh} << (8 * hcnt));
  assign total    = hcnt + (use_in ? n_in : '0);
  assign hold_nx  = DW'(comb >> (8 * need));

  assign emit      = busy && (total >= need);
  assign out_valid = emit;
  assign in_ready  = use_in && (!emit || out_ready);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = emit && out_ready;

  assign out_data = (comb[DW-1:0] & bit_mask(lane_mask(need))) << (8 * lane_out);
  assign out_strb = lane_mask(need) << lane_out;
  assign out_last = emit && (CNT_W'(need) == rem_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;  hcnt <= '0;  rem_in <= '0;  rem_out <= '0;
      so_q <= '0;  do_q <= '0;  incr_q <= 1'b0;
      first_in <= 1'b0;  first_out <= 1'b0;
    end else if (start && !busy && byte_count != '0) begin
      so_q <= src_off;  do_q <= dst_off;  incr_q <= dst_incr;
      rem_in <= byte_count;  rem_out <= byte_count;
      first_in <= 1'b1;  first_out <= 1'b1;
      hold <= '0;  hcnt <= '0;
    end else begin
      if (in_fire) begin
        rem_in   <= rem_in - CNT_W'(n_in);
        first_in <= 1'b0;
      end
      if (out_fire) begin
        hold      <= hold_nx;
        hcnt      <= total - need;
        rem_out   <= rem_out - CNT_W'(need);
        first_out <= 1'b0;
      end else if (in_fire) begin
        hold <= comb[DW-1:0];
        hcnt <= total;
      end
    end
  end

  assert_byte_balance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_out == rem_in + CNT_W'(hcnt));

  assert_fixed_low_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !incr_q) |-> (out_strb & lane_mask(NW'(do_q))) == '0);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_strb)));

  assert_stall_no_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !out_valid && !in_ready);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));
endmodule

// File: tb/byte_realigner_tb.sv
module byte_realigner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  src_off = '0, dst_off = '0;
  logic        dst_incr = 1'b1;
  logic [15:0] byte_count = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid, out_ready = 1'b1, out_last;
  logic [63:0] out_data;
  logic [7:0]  out_strb;

  always #5 clk = ~clk;

  byte_realigner dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_off(src_off), .dst_off(dst_off),
    .dst_incr(dst_incr), .byte_count(byte_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_strb(out_strb), .out_last(out_last)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0]  srcb  [0:511];
  logic [63:0] exp_d [0:127];
  logic [7:0]  exp_s [0:127];
  logic [63:0] rec_d [0:127];
  logic [7:0]  rec_s [0:127];
  logic        rec_l [0:127];
  logic        rec_iv[0:127];
  int n_exp, n_rec;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic run_xfer(input int so, input int dof, input bit incr, input int cnt,
                          input bit gaps, input bit stalls, input bit inject,
                          input bit flush, input string req_data, input string req_cnt);
    n_exp = 0;
    n_rec = 0;
    for (int i = 0; i < 128; i++) begin exp_d[i] = '0; exp_s[i] = '0; end
    for (int k = 0; k < cnt; k++) begin
      int p, b, l;
      srcb[k] = 8'((k * 37 + cnt + so * 11) & 255);
      p = incr ? dof + k : (k / (8 - dof)) * 8 + dof + k % (8 - dof);
      b = p / 8;
      l = p % 8;
      exp_d[b][8*l +: 8] = srcb[k];
      exp_s[b][l] = 1'b1;
      if (b + 1 > n_exp) n_exp = b + 1;
    end
    @(posedge clk); #1;
    src_off = 3'(so); dst_off = 3'(dof); dst_incr = incr; byte_count = 16'(cnt);
    start = 1'b1;
    out_ready = !stalls;
    @(posedge clk); #1;
    start = 1'b0;
    fork
      begin
        int nb;
        nb = (so + cnt + 7) / 8;
        for (int b = 0; b < nb; b++) begin
          bit acc;
          if (gaps && b % 2 == 1) begin in_valid = 1'b0; @(posedge clk); #1; end
          for (int l = 0; l < 8; l++) begin
            int k;
            k = b * 8 + l - so;
            in_data[8*l +: 8] = (k >= 0 && k < cnt) ? srcb[k] : 8'hEE;
          end
          in_valid = 1'b1;
          acc = 1'b0;
          while (!acc) begin @(negedge clk); acc = in_ready; @(posedge clk); #1; end
          in_valid = 1'b0;
          if (inject && b == 0) begin
            src_off = 3'd7; dst_off = 3'd0; dst_incr = ~incr; byte_count = 16'd3;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
          end
        end
      end
      begin
        int cyc;
        bit done, pst;
        logic [63:0] pd;
        logic [7:0] ps;
        cyc = 0; done = 1'b0; pst = 1'b0; pd = '0; ps = '0;
        while (!done && cyc < 4000) begin
          @(negedge clk);
          cyc++;
          if (pst) check(out_valid && out_data == pd && out_strb == ps, "R8",
                         "word held under stall", out_data, pd);
          if (out_valid && !out_ready) check(!in_ready, "R8", "in_ready under stall",
                                             64'(in_ready), 64'd0);
          pst = out_valid && !out_ready;
          pd = out_data;
          ps = out_strb;
          if (out_valid && out_ready && n_rec < 128) begin
            rec_d[n_rec] = out_data; rec_s[n_rec] = out_strb;
            rec_l[n_rec] = out_last; rec_iv[n_rec] = in_valid;
            n_rec++;
            if (out_last) done = 1'b1;
          end
          @(posedge clk); #1;
          out_ready = !(stalls && (cyc % 3 == 0));
        end
        out_ready = 1'b1;
      end
    join
    check(n_rec == n_exp, req_cnt, "word count", 64'(n_rec), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_rec; i++) begin
      logic [63:0] m;
      for (int l = 0; l < 8; l++) m[8*l +: 8] = {8{exp_s[i][l]}};
      check(rec_s[i] == exp_s[i], req_cnt, $sformatf("strobe of word %0d", i),
            64'(rec_s[i]), 64'(exp_s[i]));
      check((rec_d[i] & m) == exp_d[i], req_data, $sformatf("data of word %0d", i),
            rec_d[i] & m, exp_d[i]);
      check(rec_l[i] == (i == n_exp - 1), "R6", $sformatf("last flag of word %0d", i),
            64'(rec_l[i]), 64'(i == n_exp - 1));
    end
    if (flush) check(n_rec > 0 && rec_iv[n_rec-1] == 1'b0, "R7", "flush without input",
                     64'(rec_iv[n_rec-1]), 64'd0);
    @(negedge clk);
    check(!out_valid && !in_ready, "R6", "idle after last word",
          {62'd0, out_valid, in_ready}, 64'd0);
  endtask

  task automatic t_reset_R9();
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !in_ready, "R9", "outputs in reset", {62'd0, out_valid, in_ready}, 64'd0);
    in_valid = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_zero_count_R10();
    @(posedge clk); #1;
    byte_count = '0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; in_valid = 1'b1; in_data = 64'h0123456789ABCDEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid && !in_ready, "R10", "zero count stays idle",
            {62'd0, out_valid, in_ready}, 64'd0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_aligned_R4();   run_xfer(0, 0, 1'b1, 32, 0, 0, 0, 0, "R2", "R4"); endtask
  task automatic t_shift_up_R2();  run_xfer(3, 5, 1'b1, 29, 0, 0, 0, 0, "R2", "R4"); endtask
  task automatic t_shift_dn_R8();  run_xfer(6, 1, 1'b1, 40, 1, 1, 0, 0, "R2", "R4"); endtask
  task automatic t_merge_R3();     run_xfer(4, 0, 1'b1, 8, 0, 0, 0, 0, "R3", "R4"); endtask
  task automatic t_one_byte_R3();  run_xfer(7, 0, 1'b1, 1, 0, 0, 0, 0, "R3", "R4"); endtask
  task automatic t_fixed_R5();     run_xfer(2, 5, 1'b0, 13, 0, 1, 0, 0, "R5", "R5"); endtask
  task automatic t_fixed_full_R5(); run_xfer(3, 0, 1'b0, 20, 1, 0, 0, 0, "R5", "R5"); endtask
  task automatic t_flush_R7();     run_xfer(0, 4, 1'b1, 8, 0, 0, 0, 1, "R2", "R4"); endtask
  task automatic t_busy_start_R1(); run_xfer(1, 2, 1'b1, 50, 0, 0, 1, 0, "R1", "R1"); endtask

  initial begin
    t_reset_R9();
    t_aligned_R4();
    t_shift_up_R2();
    t_shift_dn_R8();
    t_merge_R3();
    t_one_byte_R3();
    t_fixed_R5();
    t_fixed_full_R5();
    t_flush_R7();
    t_busy_start_R1();
    t_zero_count_R10();
    t_aligned_R4();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule